// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is the transmit and chip-select side of an SPI master. Software writes 32-bit transmit words into a single holding register. Each word carries up to 16 data bits, a 4-bit select code and a flag marking the final word of a burst. The sequencer drives one of four active-low select lines, shifts the data out MSB first in clock mode 0, and releases or keeps the select line as each word's flag directs.

Two select modes are available. In fixed mode the configured select code is used and the word's own code is ignored. In variable mode every word names its own target, so a burst can move between peripherals without reconfiguration. The sequencer inserts three programmable delays, each counted in system clocks: a gap between releasing one select and asserting the next, a setup time from select assertion to the first rising clock edge, and a pause between consecutive words while a select is held. Enable and disable commands gate the start of new words. A disable lets the word in flight finish and then releases the select.

Top module: `spi_cs_sequencer`

## Requirements
- R1: The four select outputs `cs_n` are active low, and at most one is low at any time. After reset all four are high.
- R2: Word layout: bit 24 is the last-word flag, bits 19:16 are the select code and bits 15:0 are the data. Bits 31:25 and 23:20 are ignored. In 8-bit mode only data bits 7:0 are sent and bits 15:8 are ignored.
- R3: With `cfg_var_sel`=0 the select comes from `cfg_fixed_cs`, and the word's select code has no effect.
- R4: With `cfg_var_sel`=1 the word's select code picks the line: code k in 0..3 drives `cs_n[k]` low.
- R5: A resolved select code above 3 (including 4'hF) asserts no select and produces no clock pulses. The word is discarded.
- R6: A word with the last flag set releases its select at the same clock as its final falling `sclk` edge. A word without the flag keeps the select low. The next word for the same select then shifts without the select being re-asserted.
- R7: When the next word targets a different select, the active line is released first. All lines stay high for max(`cfg_dly_cs`,1)+1 clocks before the new line falls.
- R8: From a select falling to the first rising `sclk` edge there are max(`cfg_dly_setup`,1)+div clocks, where div is max(`cfg_div`,1).
- R9: While a select is held and the next word is already waiting, the time from the last falling `sclk` edge of one word to the first rising edge of the next is max(`cfg_dly_word`,1)+1+div clocks.
- R10: `sclk` is low whenever no select is low. Each `sclk` half period lasts div clocks. Data leave MSB first, and `mosi` changes only on a falling `sclk` edge. A word is 16 bits when `cfg_wide`=1 and 8 bits otherwise.
- R11: The block is enabled after reset. After `cmd_disable`, no new word starts: a word in flight completes, and then (or at once if the select is merely held) the select is released. `cmd_enable` resumes transfers, including a word that was written while the block was disabled. Configuration inputs are not altered.
- R12: `hold_empty` is high when the holding register is free, and a write while it is full is ignored. `tx_empty` is high only when the holding register is empty, no word is shifting or waiting, and no delay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_enable | input | 1 | One-cycle pulse that allows new words to start |
| cmd_disable | input | 1 | One-cycle pulse that stops new words and releases the select; wins over `cmd_enable` |
| cfg_var_sel | input | 1 | 0 = fixed select, 1 = select taken from each word |
| cfg_fixed_cs | input | 4 | Select code used in fixed mode |
| cfg_wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cfg_div | input | 8 | `sclk` half period in system clocks (0 treated as 1) |
| cfg_dly_cs | input | 8 | Gap between releasing one select and asserting another |
| cfg_dly_setup | input | 8 | Delay from select assertion to first clock edge |
| cfg_dly_word | input | 8 | Pause between consecutive words under a held select |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 32 | Transmit word (layout in R2) |
| hold_empty | output | 1 | Holding register can accept a word |
| tx_empty | output | 1 | Everything has been sent and no delay is running |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| cs_n | output | 4 | Active-low peripheral selects |

## Verification
On every cycle the embedded properties check the following:
- at most one select is low;
- `sclk` stays low while no select is low;
- `mosi` moves only on falling clock edges;
- a select only falls while the block is enabled;
- a final word releases its select;
- a running delay state always has a live timer;
- a full holding register ignores writes;
- `tx_empty` implies a quiet interface.

Only the directed scenarios can show the rest. That covers the exact delay lengths in clocks, the bit order and width of the shifted data, and which peripheral each word reaches in fixed and variable mode. It also covers the discarding of unmapped codes and the resume behaviour after a disable.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int SEQ_DATA_W   = 16;
   localparam int SEQ_NARROW_W = 8;
   localparam int SEQ_CODE_W   = 4;

   typedef struct packed {
      logic                    last;
      logic [SEQ_CODE_W-1:0]   code;
      logic [SEQ_DATA_W-1:0]   data;
   } seq_word_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_SETUP,
      ST_SHIFT,
      ST_WAIT
   } seq_state_t;

endpackage

// File: rtl/spi_seq_hold.sv
module spi_seq_hold
   import spi_seq_pkg::*;
#(
   parameter int WORD_W   = 32,
   parameter int LAST_POS = 24,
   parameter int CODE_LSB = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic              valid,
   output seq_word_t         word
);

   logic      valid_q;
   seq_word_t word_q;
   logic      accept;
   logic      unused_wr_bits;

   assign accept         = wr_en && !valid_q;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         word_q  <= '0;
      end else if (accept) begin
         valid_q     <= 1'b1;
         word_q.last <= wr_data[LAST_POS];
         word_q.code <= wr_data[CODE_LSB +: SEQ_CODE_W];
         word_q.data <= wr_data[SEQ_DATA_W-1:0];
      end else if (take) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign word  = word_q;

   // R12: a write into a full holding register leaves it untouched
   p_full_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !take) |=> (valid_q && $stable(word_q)));

endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             expire,
   output logic             busy
);

   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] eff;

   assign eff = (load_val == '0) ? DLY_W'(1) : load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= eff;
      else if (cnt_q != '0)   cnt_q <= cnt_q - DLY_W'(1);
   end

   assign expire = (cnt_q == DLY_W'(1));
   assign busy   = (cnt_q != '0);

   // R8: a freshly loaded count is never zero
   p_load_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int DIV_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              load_wide,
   input  logic              start,
   input  logic [DIV_W-1:0]  div,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic              busy
);

   localparam int BC_W = $clog2(DATA_W + 1);

   generate
      if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_narrow
         $error("NARROW_W must lie in 1..DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] shreg_q;
   logic              wide_q;
   logic              busy_q;
   logic              sclk_q;
   logic [DIV_W-1:0]  hc_q;
   logic [BC_W-1:0]   bc_q;
   logic [DIV_W-1:0]  div_eff;
   logic              half_end;
   logic              wide_now;

   assign div_eff  = (div == '0) ? DIV_W'(1) : div;
   assign half_end = busy_q && (hc_q == DIV_W'(1));
   assign done     = half_end && sclk_q && (bc_q == BC_W'(1));
   assign wide_now = load ? load_wide : wide_q;

   generate
      if (NARROW_W == DATA_W) begin : g_same_width
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shreg_q <= '0;
            end else if (load) begin
               shreg_q <= load_data;
            end else if (half_end && sclk_q) begin
               shreg_q <= shreg_q << 1;
            end
         end
      end else begin : g_mixed_width
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shreg_q <= '0;
            end else if (load) begin
               shreg_q <= load_wide ? load_data :
                          {load_data[NARROW_W-1:0], {(DATA_W-NARROW_W){1'b0}}};
            end else if (half_end && sclk_q) begin
               shreg_q <= shreg_q << 1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q <= 1'b0;
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         hc_q   <= '0;
         bc_q   <= '0;
      end else begin
         if (load) wide_q <= load_wide;
         if (start) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            hc_q   <= div_eff;
            bc_q   <= wide_now ? BC_W'(DATA_W) : BC_W'(NARROW_W);
         end else if (busy_q) begin
            if (hc_q == DIV_W'(1)) begin
               hc_q <= div_eff;
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
               end else begin
                  sclk_q <= 1'b0;
                  bc_q   <= bc_q - BC_W'(1);
                  if (bc_q == BC_W'(1)) busy_q <= 1'b0;
               end
            end else begin
               hc_q <= hc_q - DIV_W'(1);
            end
         end
      end
   end

   assign sclk = sclk_q;
   assign mosi = shreg_q[DATA_W-1];
   assign busy = busy_q;

   // R10: data move only when the serial clock falls
   p_mosi_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$fell(sclk_q)) |-> $stable(shreg_q[DATA_W-1]));

   // R10: the serial clock is low whenever the shifter is idle
   p_sclk_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);

endmodule

// File: rtl/spi_seq_csdec.sv
module spi_seq_csdec #(
   parameter int NUM_CS = 4,
   parameter int IDX_W  = 2
) (
   input  logic             act,
   input  logic [IDX_W-1:0] idx,
   output logic [NUM_CS-1:0] cs_n
);

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_line
         assign cs_n[i] = !(act && (idx == IDX_W'(i)));
      end
   endgenerate

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
   import spi_seq_pkg::*;
#(
   parameter int NUM_CS   = 4,
   parameter int DLY_W    = 8,
   parameter int DIV_W    = 8,
   parameter int WORD_W   = 32,
   parameter int LAST_POS = 24,
   parameter int CODE_LSB = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_enable,
   input  logic                  cmd_disable,
   input  logic                  cfg_var_sel,
   input  logic [SEQ_CODE_W-1:0] cfg_fixed_cs,
   input  logic                  cfg_wide,
   input  logic [DIV_W-1:0]      cfg_div,
   input  logic [DLY_W-1:0]      cfg_dly_cs,
   input  logic [DLY_W-1:0]      cfg_dly_setup,
   input  logic [DLY_W-1:0]      cfg_dly_word,
   input  logic                  wr_en,
   input  logic [WORD_W-1:0]     wr_data,
   output logic                  hold_empty,
   output logic                  tx_empty,
   output logic                  sclk,
   output logic                  mosi,
   output logic [NUM_CS-1:0]     cs_n
);

   localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam logic [SEQ_CODE_W-1:0] NUM_CS_C = SEQ_CODE_W'(NUM_CS);

   generate
      if (NUM_CS < 1 || NUM_CS > (1 << SEQ_CODE_W) - 1) begin : g_bad_cs
         $error("NUM_CS must leave the all-ones code unmapped");
      end
      if (LAST_POS >= WORD_W || CODE_LSB + SEQ_CODE_W > WORD_W) begin : g_bad_pos
         $error("word fields exceed WORD_W");
      end
      if (CODE_LSB < SEQ_DATA_W || LAST_POS < SEQ_DATA_W) begin : g_bad_overlap
         $error("control fields overlap the data field");
      end
      if (DLY_W < 1 || DIV_W < 1) begin : g_bad_cnt
         $error("counter widths must be positive");
      end
   endgenerate

   seq_state_t            state_q, st_d;
   logic                  en_q;
   logic                  cs_act_q, cs_act_d;
   logic [IDX_W-1:0]      cs_idx_q, cs_idx_d;
   logic                  pend_q, pend_d;
   logic                  last_q;

   logic                  hold_valid;
   seq_word_t             hold_word;
   logic                  take;
   logic [SEQ_CODE_W-1:0] sel_code;
   logic                  sel_ok;
   logic [IDX_W-1:0]      sel_idx;

   logic                  tmr_load;
   logic [DLY_W-1:0]      tmr_val;
   logic                  tmr_expire;
   logic                  tmr_busy;

   logic                  sh_load;
   logic                  sh_start;
   logic                  sh_done;
   logic                  sh_busy;

   spi_seq_hold #(
      .WORD_W   (WORD_W),
      .LAST_POS (LAST_POS),
      .CODE_LSB (CODE_LSB)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .valid   (hold_valid),
      .word    (hold_word)
   );

   assign sel_code = cfg_var_sel ? hold_word.code : cfg_fixed_cs;
   assign sel_ok   = (sel_code < NUM_CS_C);
   assign sel_idx  = sel_code[IDX_W-1:0];

   spi_seq_timer #(.DLY_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire),
      .busy     (tmr_busy)
   );

   spi_seq_shifter #(
      .DATA_W   (SEQ_DATA_W),
      .NARROW_W (SEQ_NARROW_W),
      .DIV_W    (DIV_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_data (hold_word.data),
      .load_wide (cfg_wide),
      .start     (sh_start),
      .div       (cfg_div),
      .sclk      (sclk),
      .mosi      (mosi),
      .done      (sh_done),
      .busy      (sh_busy)
   );

   spi_seq_csdec #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_csdec (
      .act  (cs_act_q),
      .idx  (cs_idx_q),
      .cs_n (cs_n)
   );

   // Sequencing decisions
   always_comb begin
      st_d     = state_q;
      cs_act_d = cs_act_q;
      cs_idx_d = cs_idx_q;
      pend_d   = pend_q;
      tmr_load = 1'b0;
      tmr_val  = cfg_dly_cs;
      take     = 1'b0;
      sh_load  = 1'b0;
      sh_start = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (cs_act_q && !en_q) begin
               cs_act_d = 1'b0;
               st_d     = ST_GAP;
               tmr_load = 1'b1;
            end else if (pend_q) begin
               if (en_q) begin
                  cs_act_d = 1'b1;
                  pend_d   = 1'b0;
                  st_d     = ST_SETUP;
                  tmr_load = 1'b1;
                  tmr_val  = cfg_dly_setup;
               end
            end else if (en_q && hold_valid) begin
               take    = 1'b1;
               sh_load = sel_ok;
               if (sel_ok) begin
                  if (cs_act_q && cs_idx_q == sel_idx) begin
                     sh_start = 1'b1;
                     st_d     = ST_SHIFT;
                  end else if (cs_act_q) begin
                     cs_act_d = 1'b0;
                     cs_idx_d = sel_idx;
                     pend_d   = 1'b1;
                     st_d     = ST_GAP;
                     tmr_load = 1'b1;
                  end else begin
                     cs_act_d = 1'b1;
                     cs_idx_d = sel_idx;
                     st_d     = ST_SETUP;
                     tmr_load = 1'b1;
                     tmr_val  = cfg_dly_setup;
                  end
               end
            end
         end
         ST_GAP: begin
            if (tmr_expire) st_d = ST_IDLE;
         end
         ST_SETUP: begin
            if (tmr_expire) begin
               sh_start = 1'b1;
               st_d     = ST_SHIFT;
            end
         end
         ST_SHIFT: begin
            if (sh_done) begin
               tmr_load = 1'b1;
               if (last_q || !en_q) begin
                  cs_act_d = 1'b0;
                  st_d     = ST_GAP;
               end else begin
                  tmr_val  = cfg_dly_word;
                  st_d     = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            if (tmr_expire) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         en_q     <= 1'b1;
         cs_act_q <= 1'b0;
         cs_idx_q <= '0;
         pend_q   <= 1'b0;
         last_q   <= 1'b0;
      end else begin
         state_q  <= st_d;
         cs_act_q <= cs_act_d;
         cs_idx_q <= cs_idx_d;
         pend_q   <= pend_d;
         if (take) last_q <= hold_word.last;
         if (cmd_disable)     en_q <= 1'b0;
         else if (cmd_enable) en_q <= 1'b1;
      end
   end

   assign hold_empty = !hold_valid;
   assign tx_empty   = (state_q == ST_IDLE) && !hold_valid && !pend_q;

   // R1: never more than one select low
   p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R10: no serial clock without a select
   p_sclk_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk);

   // R11: a select only falls while enabled
   p_assert_needs_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(&cs_n) |-> $past(en_q));

   // R6: a final word leaves every select high
   p_release_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_done && last_q) |=> (&cs_n));

   // R12: empty status implies a quiet interface
   p_empty_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> (hold_empty && !sclk && !sh_busy));

   // R8: every delay state runs on a live timer
   p_delay_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP || state_q == ST_SETUP || state_q == ST_WAIT) |-> tmr_busy);

endmodule

// File: tb/spi_cs_sequencer_tb.sv
module spi_cs_sequencer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_enable = 1'b0, cmd_disable = 1'b0;
   logic        cfg_var_sel = 1'b0;
   logic [3:0]  cfg_fixed_cs = 4'd0;
   logic        cfg_wide = 1'b0;
   logic [7:0]  cfg_div = 8'd2;
   logic [7:0]  cfg_dly_cs = 8'd2, cfg_dly_setup = 8'd3, cfg_dly_word = 8'd2;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        hold_empty, tx_empty, sclk, mosi;
   logic [3:0]  cs_n;

   spi_cs_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
      .cfg_var_sel(cfg_var_sel), .cfg_fixed_cs(cfg_fixed_cs), .cfg_wide(cfg_wide),
      .cfg_div(cfg_div), .cfg_dly_cs(cfg_dly_cs), .cfg_dly_setup(cfg_dly_setup),
      .cfg_dly_word(cfg_dly_word), .wr_en(wr_en), .wr_data(wr_data),
      .hold_empty(hold_empty), .tx_empty(tx_empty), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) cyc++;

   // ---------------- monitor ----------------
   logic [3:0]  pcs = 4'hF;
   logic        psclk = 1'b0;
   int          mon_bits = 8;
   int          nb = 0;
   logic [15:0] acc = '0;
   int          frames = 0, words = 0, viol = 0;
   int          cs_fall_t = 0, cs_rise_t = 0, fall_t = 0, rise_t = 0;
   bit          first_pend = 0, had_rise = 0;
   int          meas_setup = -1, meas_word_gap = -1, meas_cs_gap = -1;
   int          meas_high = -1, meas_low = -1;
   logic [15:0] w_data [0:63];
   logic [3:0]  w_cs   [0:63];

   always @(negedge clk) begin
      if (pcs == 4'hF && cs_n != 4'hF) begin
         frames++;
         cs_fall_t = cyc;
         first_pend = 1;
         if (had_rise) meas_cs_gap = cyc - cs_rise_t;
      end
      if (pcs != 4'hF && cs_n == 4'hF) begin
         cs_rise_t = cyc;
         had_rise = 1;
      end
      if (!psclk && sclk) begin
         if (first_pend) begin
            meas_setup = cyc - cs_fall_t;
            first_pend = 0;
         end else if (nb == 0) begin
            meas_word_gap = cyc - fall_t;
         end else begin
            meas_low = cyc - fall_t;
         end
         rise_t = cyc;
         acc = {acc[14:0], mosi};
         nb++;
         if (nb == mon_bits) begin
            if (words < 64) begin
               w_data[words] = (mon_bits == 8) ? {8'h00, acc[7:0]} : acc;
               w_cs[words]   = cs_n;
            end
            words++;
            nb = 0;
         end
      end
      if (psclk && !sclk) begin
         fall_t = cyc;
         meas_high = cyc - rise_t;
      end
      if (cs_n == 4'hF && sclk) viol++;
      if ($countones(~cs_n) > 1) viol++;
      pcs = cs_n;
      psclk = sclk;
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic last, input logic [3:0] code, input logic [15:0] data);
      return {7'h7F, last, 4'hF, code, data};
   endfunction

   task automatic write_word(input logic [31:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic write_when_free(input logic [31:0] w);
      while (!hold_empty) @(negedge clk);
      write_word(w);
   endtask

   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (!tx_empty) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_enable();
      @(negedge clk); cmd_enable = 1'b1;
      @(negedge clk); cmd_enable = 1'b0;
   endtask

   task automatic pulse_disable();
      @(negedge clk); cmd_disable = 1'b1;
      @(negedge clk); cmd_disable = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R1 cs_n after reset", int'(cs_n), 15);
      chk("R10 sclk after reset", int'(sclk), 0);
      chk("R12 tx_empty after reset", int'(tx_empty), 1);
      chk("R12 hold_empty after reset", int'(hold_empty), 1);
   endtask

   task automatic t_fixed();
      int f0 = frames, w0 = words;
      cfg_var_sel = 1'b0; cfg_fixed_cs = 4'd2; cfg_wide = 1'b0; mon_bits = 8;
      write_word(mk(1'b1, 4'd0, 16'hFFA5));
      repeat (2) @(negedge clk);
      chk("R12 tx_empty low while busy", int'(tx_empty), 0);
      wait_idle();
      chk("R3 one frame", frames - f0, 1);
      chk("R3 one word", words - w0, 1);
      chk("R3 fixed select line", int'(w_cs[w0]), 4'b1011);
      chk("R2 R10 8-bit data MSB first", int'(w_data[w0]), 16'h00A5);
      chk("R8 setup clocks", meas_setup, 3 + 2);
      chk("R10 high half period", meas_high, 2);
      chk("R10 low half period", meas_low, 2);
      chk("R6 released after last", int'(cs_n), 15);
   endtask

   task automatic t_var_hold();
      int f0 = frames, w0 = words;
      cfg_var_sel = 1'b1; mon_bits = 8;
      write_word(mk(1'b0, 4'd1, 16'h003C));
      write_when_free(mk(1'b1, 4'd1, 16'h00C3));
      wait_idle();
      chk("R6 select held across words", frames - f0, 1);
      chk("R4 two words", words - w0, 2);
      chk("R4 first word line", int'(w_cs[w0]), 4'b1101);
      chk("R4 second word line", int'(w_cs[w0+1]), 4'b1101);
      chk("R4 first word data", int'(w_data[w0]), 16'h003C);
      chk("R4 second word data", int'(w_data[w0+1]), 16'h00C3);
      chk("R9 between-word clocks", meas_word_gap, 2 + 1 + 2);
   endtask

   task automatic t_switch();
      int f0 = frames, w0 = words;
      cfg_var_sel = 1'b1; mon_bits = 8;
      write_word(mk(1'b0, 4'd0, 16'h0081));
      write_when_free(mk(1'b1, 4'd3, 16'h0042));
      wait_idle();
      chk("R7 two frames", frames - f0, 2);
      chk("R7 first line", int'(w_cs[w0]), 4'b1110);
      chk("R7 second line", int'(w_cs[w0+1]), 4'b0111);
      chk("R7 second data", int'(w_data[w0+1]), 16'h0042);
      chk("R7 select gap clocks", meas_cs_gap, 2 + 1);
   endtask

   task automatic t_wide();
      int w0 = words;
      cfg_var_sel = 1'b1; cfg_wide = 1'b1; mon_bits = 16;
      cfg_div = 8'd3; cfg_dly_setup = 8'd0;
      write_word(mk(1'b1, 4'd2, 16'hBEEF));
      wait_idle();
      chk("R10 16-bit word count", words - w0, 1);
      chk("R10 16-bit data", int'(w_data[w0]), 16'hBEEF);
      chk("R8 zero setup gives one clock", meas_setup, 1 + 3);
      chk("R10 half period divider 3", meas_high, 3);
      chk("R10 low half divider 3", meas_low, 3);
      cfg_div = 8'd2; cfg_dly_setup = 8'd3; cfg_wide = 1'b0; mon_bits = 8;
   endtask

   task automatic t_suppress();
      int f0 = frames, w0 = words;
      cfg_var_sel = 1'b1;
      write_word(mk(1'b1, 4'hF, 16'h00FF));
      wait_idle();
      write_word(mk(1'b1, 4'd5, 16'h00FF));
      wait_idle();
      chk("R5 no frame for unmapped codes", frames - f0, 0);
      chk("R5 no clocks for unmapped codes", words - w0, 0);
      chk("R5 nb idle", nb, 0);
      chk("R5 holding register drained", int'(hold_empty), 1);
   endtask

   task automatic t_disable();
      int w0;
      cfg_var_sel = 1'b1;
      w0 = words;
      write_word(mk(1'b0, 4'd2, 16'h0066));
      wait_idle();
      chk("R6 select held without last flag", int'(cs_n), 4'b1011);
      pulse_disable();
      repeat (4) @(negedge clk);
      chk("R11 held select released on disable", int'(cs_n), 15);
      write_word(mk(1'b1, 4'd2, 16'h0099));
      write_word(mk(1'b1, 4'd2, 16'h0077));
      repeat (60) @(negedge clk);
      chk("R11 no word while disabled", words - w0, 1);
      chk("R11 select stays high while disabled", int'(cs_n), 15);
      chk("R12 hold full while disabled", int'(hold_empty), 0);
      chk("R12 tx_empty low with word waiting", int'(tx_empty), 0);
      pulse_enable();
      wait_idle();
      repeat (20) @(negedge clk);
      chk("R12 write while full ignored", words - w0, 2);
      chk("R11 resumed word data", int'(w_data[w0+1]), 16'h0099);
      // disable during a word: it still completes
      w0 = words;
      write_word(mk(1'b0, 4'd1, 16'h005A));
      while (!sclk) @(negedge clk);
      pulse_disable();
      wait_idle();
      chk("R11 word in flight completes", words - w0, 1);
      chk("R11 in-flight data intact", int'(w_data[w0]), 16'h005A);
      chk("R11 released after in-flight word", int'(cs_n), 15);
      pulse_enable();
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cyc > 100000 && !finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_fixed();
      t_var_hold();
      t_switch();
      t_wide();
      t_suppress();
      t_disable();
      chk("R1 R10 monitor violations", viol, 0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule